// File: doc/BRIEF.md
# UART Software Flow Controller

This block sits between a UART receiver, its receive FIFO and its transmit holding path, and runs in-band software flow control on its own. Each received character is compared against four programmed values: two "resume" characters and two "halt" characters. When receive-side flow control is enabled, a character that matches an enabled halt or resume value is consumed by the block and never reaches the FIFO. A received halt character pauses the local data transmitter, and a received resume character releases it. Separately, a special-character detector compares each pushed character with the second halt value and raises a sticky status bit. The character is still written to the FIFO.

On the transmit side the block watches the receive FIFO fill count. When the fill exceeds the programmed trigger level, it queues the halt character(s) for the remote end. When the fill later drops below the trigger level, it queues the resume character(s). A queued flow-control character takes the transmit holding path ahead of ordinary data at the next character boundary, which is a cycle in which the serializer accepts a character. Every comparison is masked to the programmed word length.

Top module: `swfc_top`

## Requirements
- R1: With `rx_fc_sel_i` nonzero, a valid received character that matches an enabled halt or resume value is not pushed (`rx_push_o` low in that cycle). Bit 0 of `rx_fc_sel_i` enables the pair `xon1_i`/`xoff1_i` and bit 1 enables `xon2_i`/`xoff2_i`. Any other valid character is pushed in the same cycle with its data unchanged.
- R2: With `rx_fc_sel_i` = 00, every valid received character is pushed unchanged, including characters equal to the flow-control values.
- R3: Comparisons use only the low bits given by `wlen_i`: 00 = 5 bits, 01 = 6 bits, 10 = 7 bits, 11 = 8 bits. Bit 0 of each compare value aligns with bit 0 of the received character, and higher bits are ignored.
- R4: When `spec_en_i` is high and a pushed character matches `xoff2_i` under the word-length mask, `spec_flag_o` is high from the next cycle. The character is still pushed.
- R5: `spec_flag_o` stays set until a cycle with `isr_read_i` high, and clears one cycle later. A new detection in the same cycle as the read keeps it set.
- R6: While no halt is outstanding and `fifo_level_i` > `trig_level_i`, the block sends a halt sequence once. `tx_fc_sel_i` selects the sequence: 01 sends xoff1, 10 sends xoff2, 11 sends xoff1 then xoff2, and 00 sends nothing and leaves the state unchanged.
- R7: While a halt is outstanding and `fifo_level_i` < `trig_level_i`, the block sends the resume sequence once, with the same selection (xon1/xon2). A fill equal to the trigger level, or a repeated crossing in the same direction, sends nothing.
- R8: While a flow-control sequence is pending, `txo_data_o` carries the flow character, `txo_valid_o` is high and `tx_data_ready_o` is low. Ordinary data is accepted only when `txo_ready_i` is high and no sequence is pending.
- R9: A stripped halt character sets `tx_paused_o` from the next cycle and withholds ordinary data (`txo_valid_o` low unless a flow sequence is pending). A stripped resume character clears it.
- R10: After reset, `spec_flag_o`, `tx_paused_o` and `txo_valid_o` are low and no halt is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wlen_i | input | 2 | Word length select (5/6/7/8 bits) |
| rx_fc_sel_i | input | 2 | Receive-side flow-control pair enables |
| tx_fc_sel_i | input | 2 | Transmit-side flow sequence select |
| spec_en_i | input | 1 | Special-character detection enable |
| xon1_i | input | 8 | Resume character 1 |
| xon2_i | input | 8 | Resume character 2 |
| xoff1_i | input | 8 | Halt character 1 |
| xoff2_i | input | 8 | Halt character 2 / special character |
| trig_level_i | input | 6 | FIFO fill trigger level |
| fifo_level_i | input | 6 | Current receive FIFO fill |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_push_o | output | 1 | Write strobe to receive FIFO |
| rx_push_data_o | output | 8 | Data to receive FIFO |
| isr_read_i | input | 1 | Interrupt status read, clears special flag |
| spec_flag_o | output | 1 | Special character seen |
| tx_data_valid_i | input | 1 | Ordinary transmit data available |
| tx_data_i | input | 8 | Ordinary transmit data |
| tx_data_ready_o | output | 1 | Ordinary data accepted this cycle |
| txo_valid_o | output | 1 | Character offered to serializer |
| txo_data_o | output | 8 | Character offered to serializer |
| txo_ready_i | input | 1 | Serializer takes a character (character boundary) |
| tx_paused_o | output | 1 | Remote end has halted local data |

## Verification
The bench sweeps random word lengths, pair enables and characters that partly match the compare values. A design that compares all eight bits, or that drops the mask, would strip or keep the wrong characters. The threshold tests hold the fill above, at and below the trigger level for many cycles. A design without the outstanding-halt state would resend halt or resume characters, and one that uses greater-or-equal would fire at the trigger level itself. Other directed cases cover a flow character arriving while data is stalled, which a design without priority would let data pass. They also cover a status read in the same cycle as a new special-character match, where a clear-first design loses the detection.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W = 8;
  localparam int NCMP   = 4;
  // compare slot order
  localparam int SLOT_XON1  = 0;
  localparam int SLOT_XON2  = 1;
  localparam int SLOT_XOFF1 = 2;
  localparam int SLOT_XOFF2 = 3;

  typedef enum logic {FC_HALT = 1'b0, FC_RESUME = 1'b1} fc_kind_e;

  function automatic logic [CHAR_W-1:0] wlen_mask(input logic [1:0] wlen);
    return {CHAR_W{1'b1}} >> (2'd3 - wlen);
  endfunction
endpackage

// File: rtl/swfc_char_match.sv
module swfc_char_match
  import swfc_pkg::*;
#(
  parameter int N = NCMP
) (
  input  logic [CHAR_W-1:0]        char_i,
  input  logic [CHAR_W-1:0]        mask_i,
  input  logic [N-1:0][CHAR_W-1:0] cmp_i,
  output logic [N-1:0]             hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = ~|((char_i ^ cmp_i[g]) & mask_i);
  end
endmodule

// File: rtl/swfc_rx_filter.sv
module swfc_rx_filter
  import swfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wlen_i,
  input  logic [1:0]        rx_fc_sel_i,
  input  logic              spec_en_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              isr_read_i,
  output logic              rx_push_o,
  output logic [CHAR_W-1:0] rx_push_data_o,
  output logic              spec_flag_o,
  output logic              paused_o
);
  logic [NCMP-1:0][CHAR_W-1:0] cmp;
  logic [NCMP-1:0]             hit;
  logic halt_hit, resume_hit, strip, spec_hit;
  logic spec_q, paused_q;

  always_comb begin
    cmp[SLOT_XON1]  = xon1_i;
    cmp[SLOT_XON2]  = xon2_i;
    cmp[SLOT_XOFF1] = xoff1_i;
    cmp[SLOT_XOFF2] = xoff2_i;
  end

  swfc_char_match #(.N(NCMP)) u_match (
    .char_i (rx_data_i),
    .mask_i (wlen_mask(wlen_i)),
    .cmp_i  (cmp),
    .hit_o  (hit)
  );

  assign halt_hit   = (rx_fc_sel_i[0] & hit[SLOT_XOFF1]) | (rx_fc_sel_i[1] & hit[SLOT_XOFF2]);
  assign resume_hit = (rx_fc_sel_i[0] & hit[SLOT_XON1])  | (rx_fc_sel_i[1] & hit[SLOT_XON2]);
  assign strip      = halt_hit | resume_hit;

  assign rx_push_o      = rx_valid_i & ~strip;
  assign rx_push_data_o = rx_data_i;
  assign spec_hit       = rx_push_o & spec_en_i & hit[SLOT_XOFF2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q   <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      // detection wins over a same-cycle status read
      if (spec_hit)        spec_q <= 1'b1;
      else if (isr_read_i) spec_q <= 1'b0;
      if (rx_valid_i && halt_hit)        paused_q <= 1'b1;
      else if (rx_valid_i && resume_hit) paused_q <= 1'b0;
    end
  end

  assign spec_flag_o = spec_q;
  assign paused_o    = paused_q;
endmodule

// File: rtl/swfc_level_mon.sv
module swfc_level_mon
  import swfc_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             idle_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             req_o,
  output fc_kind_e         kind_o
);
  logic halt_out_q;

  always_comb begin
    kind_o = halt_out_q ? FC_RESUME : FC_HALT;
    req_o  = en_i && idle_i &&
             (halt_out_q ? (level_i < trig_i) : (level_i > trig_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    halt_out_q <= 1'b0;
    else if (req_o) halt_out_q <= ~halt_out_q;
  end
endmodule

// File: rtl/swfc_tx_arb.sv
module swfc_tx_arb
  import swfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  fc_kind_e          kind_i,
  input  logic [1:0]        sel_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic              paused_i,
  input  logic              data_valid_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              data_ready_o,
  output logic              txo_valid_o,
  output logic [CHAR_W-1:0] txo_data_o,
  input  logic              txo_ready_i,
  output logic              busy_o
);
  logic       busy_q, second_q;
  fc_kind_e   kind_q;
  logic [1:0] sel_q;
  logic [CHAR_W-1:0] fc_char;

  always_comb begin
    if (kind_q == FC_HALT) fc_char = second_q ? xoff2_i : xoff1_i;
    else                   fc_char = second_q ? xon2_i  : xon1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      second_q <= 1'b0;
      kind_q   <= FC_HALT;
      sel_q    <= 2'b00;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q   <= 1'b1;
        kind_q   <= kind_i;
        sel_q    <= sel_i;
        second_q <= (sel_i == 2'b10);
      end
    end else if (txo_ready_i) begin
      if (!second_q && sel_q == 2'b11) second_q <= 1'b1;
      else                             busy_q   <= 1'b0;
    end
  end

  assign txo_valid_o  = busy_q | (data_valid_i & ~paused_i);
  assign txo_data_o   = busy_q ? fc_char : data_i;
  assign data_ready_o = ~busy_q & ~paused_i & txo_ready_i;
  assign busy_o       = busy_q;
endmodule

// File: rtl/swfc_top.sv
module swfc_top
  import swfc_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wlen_i,
  input  logic [1:0]        rx_fc_sel_i,
  input  logic [1:0]        tx_fc_sel_i,
  input  logic              spec_en_i,
  input  logic [7:0]        xon1_i,
  input  logic [7:0]        xon2_i,
  input  logic [7:0]        xoff1_i,
  input  logic [7:0]        xoff2_i,
  input  logic [LVL_W-1:0]  trig_level_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_push_o,
  output logic [7:0]        rx_push_data_o,
  input  logic              isr_read_i,
  output logic              spec_flag_o,
  input  logic              tx_data_valid_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_data_ready_o,
  output logic              txo_valid_o,
  output logic [7:0]        txo_data_o,
  input  logic              txo_ready_i,
  output logic              tx_paused_o
);
  logic     seq_busy, fc_req;
  fc_kind_e fc_kind;

  swfc_rx_filter u_rx (
    .clk_i, .rst_ni, .wlen_i, .rx_fc_sel_i, .spec_en_i,
    .xon1_i, .xon2_i, .xoff1_i, .xoff2_i,
    .rx_valid_i, .rx_data_i, .isr_read_i,
    .rx_push_o, .rx_push_data_o, .spec_flag_o,
    .paused_o (tx_paused_o)
  );

  swfc_level_mon #(.LVL_W(LVL_W)) u_lvl (
    .clk_i, .rst_ni,
    .en_i    (|tx_fc_sel_i),
    .idle_i  (~seq_busy),
    .level_i (fifo_level_i),
    .trig_i  (trig_level_i),
    .req_o   (fc_req),
    .kind_o  (fc_kind)
  );

  swfc_tx_arb u_arb (
    .clk_i, .rst_ni,
    .req_i        (fc_req),
    .kind_i       (fc_kind),
    .sel_i        (tx_fc_sel_i),
    .xon1_i, .xon2_i, .xoff1_i, .xoff2_i,
    .paused_i     (tx_paused_o),
    .data_valid_i (tx_data_valid_i),
    .data_i       (tx_data_i),
    .data_ready_o (tx_data_ready_o),
    .txo_valid_o, .txo_data_o, .txo_ready_i,
    .busy_o       (seq_busy)
  );
endmodule

// File: rtl/swfc_checker.sv
module swfc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rx_fc_sel_i,
  input logic       spec_en_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       rx_push_o,
  input logic [7:0] rx_push_data_o,
  input logic       isr_read_i,
  input logic       spec_flag_o,
  input logic       tx_data_ready_o,
  input logic       txo_valid_o,
  input logic [7:0] txo_data_o,
  input logic       txo_ready_i,
  input logic       tx_paused_o,
  input logic       seq_busy
);
  assert_push_needs_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> rx_valid_i);
  assert_pass_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_fc_sel_i == 2'b00) |-> (rx_push_o && rx_push_data_o == rx_data_i));
  assert_flag_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spec_flag_o) |-> $past(rx_push_o && spec_en_i));
  assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_flag_o && !isr_read_i) |=> spec_flag_o);
  assert_seq_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && !txo_ready_i) |=> (txo_valid_o && $stable(txo_data_o)));
  assert_data_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |-> (!tx_data_ready_o && txo_valid_o));
  assert_pause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_paused_o && !seq_busy) |-> (!txo_valid_o && !tx_data_ready_o));
endmodule

bind swfc_top swfc_checker u_chk (
  .clk_i, .rst_ni, .rx_fc_sel_i, .spec_en_i, .rx_valid_i, .rx_data_i,
  .rx_push_o, .rx_push_data_o, .isr_read_i, .spec_flag_o,
  .tx_data_ready_o, .txo_valid_o, .txo_data_o, .txo_ready_i,
  .tx_paused_o, .seq_busy
);

// File: tb/swfc_top_test.sv
module swfc_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] wlen = 2'b11, rx_sel = 2'b00, tx_sel = 2'b00;
  logic spec_en = 1'b0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h12, xoff1 = 8'h13, xoff2 = 8'h14;
  logic [5:0] trig = 6'd8, level = 6'd0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_push, spec_flag, isr_read = 1'b0;
  logic [7:0] rx_push_data;
  logic tx_dv = 1'b0, tx_dr, txo_valid, txo_ready = 1'b0, paused;
  logic [7:0] tx_d = 8'h00, txo_data;

  int checks = 0, fails = 0;
  logic [7:0] txlog[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swfc_top uut (
    .clk_i(clk), .rst_ni(rst_n), .wlen_i(wlen), .rx_fc_sel_i(rx_sel),
    .tx_fc_sel_i(tx_sel), .spec_en_i(spec_en),
    .xon1_i(xon1), .xon2_i(xon2), .xoff1_i(xoff1), .xoff2_i(xoff2),
    .trig_level_i(trig), .fifo_level_i(level),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_push_o(rx_push), .rx_push_data_o(rx_push_data),
    .isr_read_i(isr_read), .spec_flag_o(spec_flag),
    .tx_data_valid_i(tx_dv), .tx_data_i(tx_d), .tx_data_ready_o(tx_dr),
    .txo_valid_o(txo_valid), .txo_data_o(txo_data), .txo_ready_i(txo_ready),
    .tx_paused_o(paused)
  );

  always @(posedge clk) if (rst_n && txo_valid && txo_ready) txlog.push_back(txo_data);

  function automatic logic mmatch(input logic [7:0] a, input logic [7:0] b, input logic [1:0] wl);
    logic [7:0] m;
    m = (wl == 2'b00) ? 8'h1F : (wl == 2'b01) ? 8'h3F : (wl == 2'b10) ? 8'h7F : 8'hFF;
    return (a & m) == (b & m);
  endfunction

  function automatic logic exp_strip(input logic [7:0] d, input logic [1:0] sel, input logic [1:0] wl);
    return (sel[0] && (mmatch(d, xon1, wl) || mmatch(d, xoff1, wl))) ||
           (sel[1] && (mmatch(d, xon2, wl) || mmatch(d, xoff2, wl)));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; isr_read = 1'b0; tx_dv = 1'b0;
    txo_ready = 1'b0; level = 6'd0; tx_sel = 2'b00; rx_sel = 2'b00; spec_en = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    txlog.delete();
  endtask

  task automatic rx_one(input logic [7:0] d, input logic exp_push, input string req);
    rx_valid = 1'b1; rx_data = d;
    #1;
    chk(rx_push == exp_push, req, {31'd0, rx_push}, {31'd0, exp_push});
    cyc(1);
    rx_valid = 1'b0;
  endtask

  task automatic log_chk(input int idx, input logic [7:0] exp, input string req);
    if (txlog.size() > idx) chk(txlog[idx] == exp, req, {24'd0, txlog[idx]}, {24'd0, exp});
    else chk(1'b0, req, 32'hFFFF_FFFF, {24'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(1);
    do_reset();
    // R10 reset state
    #1;
    chk(!spec_flag && !paused && !txo_valid, "R10 reset outputs", {29'd0, spec_flag, paused, txo_valid}, 32'd0);
    tx_sel = 2'b01; level = 6'd7; cyc(3); #1;
    chk(txlog.size() == 0 && !txo_valid, "R10 no halt outstanding", txlog.size(), 0);
    do_reset();

    // R1/R2/R3 random receive filtering
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d; logic e;
      wlen = 2'($urandom); rx_sel = 2'($urandom);
      case ($urandom % 5)
        0: d = xon1; 1: d = xoff2; 2: d = xoff1;
        default: d = 8'($urandom);
      endcase
      if ($urandom % 2) d = d ^ (8'hE0 & 8'($urandom));
      e = exp_strip(d, rx_sel, wlen);
      rx_valid = 1'b1; rx_data = d;
      #1;
      chk(rx_push == !e, (rx_sel == 2'b00) ? "R2 pass-through" : "R1 strip", {31'd0, rx_push}, {31'd0, !e});
      if (!e) chk(rx_push_data == d, "R1 push data", {24'd0, rx_push_data}, {24'd0, d});
      cyc(1);
    end
    rx_valid = 1'b0;
    do_reset();

    // R3 directed masking
    xoff1 = 8'hE3; rx_sel = 2'b01;
    wlen = 2'b00; rx_one(8'h03, 1'b0, "R3 5-bit ignores upper");
    wlen = 2'b11; rx_one(8'h03, 1'b1, "R3 8-bit full compare");
    wlen = 2'b10; rx_one(8'h63, 1'b0, "R3 7-bit");
    wlen = 2'b01; rx_one(8'h23, 1'b0, "R3 6-bit match");
    wlen = 2'b01; rx_one(8'h03, 1'b1, "R3 6-bit bit5 differs");
    xoff1 = 8'h13; wlen = 2'b11;
    do_reset();

    // R4/R5 special character
    spec_en = 1'b1; wlen = 2'b11;
    rx_one(8'h15, 1'b1, "R4 non-match pushed");
    #1; chk(!spec_flag, "R4 non-match no flag", {31'd0, spec_flag}, 32'd0);
    rx_one(8'h14, 1'b1, "R4 special still pushed");
    #1; chk(spec_flag, "R4 flag set", {31'd0, spec_flag}, 32'd1);
    cyc(3); #1; chk(spec_flag, "R5 flag held", {31'd0, spec_flag}, 32'd1);
    isr_read = 1'b1; rx_valid = 1'b1; rx_data = 8'h14; cyc(1);
    isr_read = 1'b0; rx_valid = 1'b0; #1;
    chk(spec_flag, "R5 set wins over read", {31'd0, spec_flag}, 32'd1);
    isr_read = 1'b1; cyc(1); isr_read = 1'b0; #1;
    chk(!spec_flag, "R5 read clears", {31'd0, spec_flag}, 32'd0);
    wlen = 2'b00; rx_one(8'hF4, 1'b1, "R3 special masked push");
    #1; chk(spec_flag, "R3 special masked match", {31'd0, spec_flag}, 32'd1);
    wlen = 2'b11;
    do_reset();

    // R6/R7 threshold sequences
    txo_ready = 1'b1; tx_sel = 2'b11;
    level = 6'd8; cyc(4); #1;
    chk(txlog.size() == 0, "R7 equal level no send", txlog.size(), 0);
    level = 6'd9; cyc(5); #1;
    chk(txlog.size() == 2, "R6 halt pair count", txlog.size(), 2);
    log_chk(0, 8'h13, "R6 xoff1 first"); log_chk(1, 8'h14, "R6 xoff2 second");
    level = 6'd20; cyc(6); level = 6'd8; cyc(4); #1;
    chk(txlog.size() == 2, "R7 no resend above/equal", txlog.size(), 2);
    level = 6'd7; cyc(5); #1;
    chk(txlog.size() == 4, "R7 resume pair count", txlog.size(), 4);
    log_chk(2, 8'h11, "R7 xon1"); log_chk(3, 8'h12, "R7 xon2");
    level = 6'd0; cyc(4); #1;
    chk(txlog.size() == 4, "R7 once per crossing", txlog.size(), 4);
    tx_sel = 2'b10; level = 6'd30; cyc(4); #1;
    chk(txlog.size() == 5, "R6 sel 10 count", txlog.size(), 5);
    log_chk(4, 8'h14, "R6 sel 10 xoff2 only");
    tx_sel = 2'b01; level = 6'd1; cyc(4); #1;
    chk(txlog.size() == 6, "R7 sel 01 count", txlog.size(), 6);
    log_chk(5, 8'h11, "R7 sel 01 xon1 only");
    tx_sel = 2'b00; level = 6'd40; cyc(4); #1;
    chk(txlog.size() == 6, "R6 sel 00 sends nothing", txlog.size(), 6);
    do_reset();

    // R8 flow character priority
    tx_sel = 2'b11; tx_dv = 1'b1; tx_d = 8'hA5; txo_ready = 1'b0;
    level = 6'd9; cyc(1); #1;
    chk(txo_valid && txo_data == 8'h13, "R8 flow char offered", {24'd0, txo_data}, 32'h13);
    chk(!tx_dr, "R8 data held off", {31'd0, tx_dr}, 32'd0);
    cyc(2); #1;
    chk(txo_data == 8'h13, "R8 holds while not ready", {24'd0, txo_data}, 32'h13);
    txo_ready = 1'b1; cyc(3); tx_dv = 1'b0; #1;
    log_chk(0, 8'h13, "R8 order 1"); log_chk(1, 8'h14, "R8 order 2"); log_chk(2, 8'hA5, "R8 data after");
    do_reset();

    // R9 pause by received halt
    rx_sel = 2'b01; txo_ready = 1'b1;
    rx_one(8'h13, 1'b0, "R9 halt stripped");
    tx_dv = 1'b1; tx_d = 8'h5A; #1;
    chk(paused && !txo_valid && !tx_dr, "R9 data withheld", {30'd0, paused, txo_valid}, 32'h2);
    tx_dv = 1'b0;
    rx_one(8'h11, 1'b0, "R9 resume stripped");
    tx_dv = 1'b1; #1;
    chk(!paused && txo_valid && tx_dr, "R9 data resumes", {30'd0, paused, txo_valid}, 32'h1);
    tx_dv = 1'b0;
    cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule